// File: doc/BRIEF.md
# Shared Two-Port Memory with Mailbox Interrupts and Token Latches

This block is a word-wide storage array that two independent agents, called left and right, reach at the same time through two complete synchronous ports. Each port has its own enable, read and write strobes, byte-lane enables, address and data. Either side can read or write any word in any cycle, whatever the other side is doing. Read data comes back one clock after the request.

Two addresses at the top of the array also act as mailboxes. When one side writes its outgoing mailbox word, the other side's interrupt line goes high. That interrupt stays high until the receiving side reads the same word. This gives each agent a doorbell without any polling.

Beside the array sits a small bank of token latches. A port reaches them by raising its token-select line; the low address bits pick a latch and data bit 0 carries the value. A side asks for a token by writing 0 and then reads the latch back: a 0 means it holds the token, and a 1 means the other side has it. A request that finds the token taken stays pending, and the token passes to it when the holder writes 1. If both sides ask for the same free token in the same cycle, exactly one of them gets it, and the winning side alternates for each latch.

Top module: `dpr_mbox_sem`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits (8192 x 16 by default). Both ports can read or write any word independently in the same cycle. Read data for a request sampled at one clock edge appears on the port's read-data output after that edge and holds until the port's next read.
- R2: Byte enable bit k gates data bits [8k+7:8k] of a write. With 16-bit words, bit 1 is the upper byte and bit 0 the lower byte. A lane whose enable is 0 keeps its stored value.
- R3: While a port's enable is low, its read and write strobes have no effect: nothing is written and its read-data output does not change.
- R4: A right-port array write to word address 2^ADDR_W-2 (0x1FFE by default) sets the left interrupt from the next cycle on, whatever the byte enables are.
- R5: A left-port array write to word address 2^ADDR_W-1 (0x1FFF by default) sets the right interrupt from the next cycle on.
- R6: A left-port read of 2^ADDR_W-2 clears the left interrupt, and a right-port read of 2^ADDR_W-1 clears the right interrupt. Any other read, including a read of the same word by the opposite port, leaves the interrupt unchanged. When a set and a clear of the same interrupt fall in the same cycle, the set wins.
- R7: After reset both interrupts are low and both read-data outputs are zero.
- R8: With token select high, an access goes to latch number address[2:0] (with SEM_N = 8) and uses data bit 0. It never touches the array. A latch read returns its value in bit 0 with every other bit zero.
- R9: Writing 0 to a latch files a request for that side. A latch read returns 0 to the side that holds the token and 1 to the other side. All latches are free after reset, so every read returns 1.
- R10: A holder keeps its token until it writes 1 to that latch. That release hands the token to a request the other side still has pending. A write of 1 by a side that does not hold the token only withdraws that side's own request.
- R11: When both sides request the same free latch in the same cycle, exactly one side is granted. The first such tie on a latch after reset goes to the left side, and each later tie on that latch goes to the side that lost the previous one.
- R12: When both ports write the same word in the same cycle, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| l_ce | input | 1 | Left port enable |
| l_rd | input | 1 | Left read strobe |
| l_wr | input | 1 | Left write strobe |
| l_sem | input | 1 | Left token-latch select |
| l_be | input | DATA_W/8 | Left byte-lane write enables |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, one cycle after the request |
| l_irq | output | 1 | Left mailbox interrupt |
| r_ce | input | 1 | Right port enable |
| r_rd | input | 1 | Right read strobe |
| r_wr | input | 1 | Right write strobe |
| r_sem | input | 1 | Right token-latch select |
| r_be | input | DATA_W/8 | Right byte-lane write enables |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, one cycle after the request |
| r_irq | output | 1 | Right mailbox interrupt |

## Verification
The bench builds the block with ADDR_W = 6, DATA_W = 16 and SEM_N = 8. This shrinks the array to 64 words, so both ports can write and read back every word, in opposite orders, within a few hundred cycles. The two mailbox words then sit at 0x3E and 0x3F, so the full-array sweep itself raises an interrupt, and the read-back sweep has to clear it. With eight latches, the bench can also force a same-cycle tie on every latch twice and check that the winning side alternates per latch.

// File: rtl/dpr_pkg.sv
// Package: types shared by the two-port memory block.
// Assumes: nothing beyond IEEE 1800-2017.
package dpr_pkg;

    // Ownership of one token latch.
    typedef enum logic [1:0] {
        SEM_FREE  = 2'd0,
        SEM_LEFT  = 2'd1,
        SEM_RIGHT = 2'd2
    } sem_owner_e;

endpackage

// File: rtl/dpr_mem_array.sv
// Module: true two-port word array with byte-lane writes and registered reads.
// Assumes: DATA_W is a multiple of 8; same-word same-cycle writes resolve to left.
// Reads return the contents before a same-cycle write (read-before-write).
module dpr_mem_array #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 16,
    localparam int NB    = DATA_W / 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_we,
    input  logic              l_re,
    input  logic [NB-1:0]     l_be,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_q,
    input  logic              r_we,
    input  logic              r_re,
    input  logic [NB-1:0]     r_be,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_q
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write both ports per byte lane; left is applied last so it wins a collision.
    always_ff @(posedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (r_we && r_be[b]) begin
                mem[r_addr][b*8 +: 8] <= r_wdata[b*8 +: 8];
            end
        end
        for (int b = 0; b < NB; b++) begin
            if (l_we && l_be[b]) begin
                mem[l_addr][b*8 +: 8] <= l_wdata[b*8 +: 8];
            end
        end
    end

    // Left read register: captures the addressed word on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q <= '0;
        end else if (l_re) begin
            l_q <= mem[l_addr];
        end
    end

    // Right read register: captures the addressed word on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else if (r_re) begin
            r_q <= mem[r_addr];
        end
    end

endmodule

// File: rtl/dpr_mailbox.sv
// Module: two doorbell flags tied to the top two word addresses.
// Index 0 is the left side, index 1 the right side. A write by the opposite
// side to this side's box word sets the flag; a read by this side clears it.
// Assumes: strobes are already qualified by port enable and not token select.
module dpr_mailbox #(
    parameter int ADDR_W = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             we,
    input  logic [1:0]             re,
    input  logic [1:0][ADDR_W-1:0] addr,
    output logic [1:0]             irq
);

    localparam logic [ADDR_W-1:0] BOX_TOP = '1;
    localparam logic [ADDR_W-1:0] BOX_LOW = BOX_TOP - ADDR_W'(1);

    for (genvar s = 0; s < 2; s++) begin : g_side
        localparam logic [ADDR_W-1:0] BOX = (s == 0) ? BOX_LOW : BOX_TOP;
        logic set_c;
        logic clr_c;

        assign set_c = we[1-s] && (addr[1-s] == BOX);
        assign clr_c = re[s] && (addr[s] == BOX);

        // Doorbell flag: set has priority over a same-cycle clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq[s] <= 1'b0;
            end else if (set_c) begin
                irq[s] <= 1'b1;
            end else if (clr_c) begin
                irq[s] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dpr_sem_bank.sv
// Module: bank of token latches shared by the two ports.
// Each latch keeps a pending-request flag per side plus an owner; a side holds
// the token while its request stays set. A same-cycle tie on a free latch is
// resolved by a per-latch priority bit that flips after every tie.
// Assumes: strobes are already qualified by port enable and token select.
module dpr_sem_bank
    import dpr_pkg::*;
#(
    parameter int SEM_N  = 8,
    localparam int SEL_W = $clog2(SEM_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l_we,
    input  logic             l_re,
    input  logic [SEL_W-1:0] l_sel,
    input  logic             l_bit,
    input  logic             r_we,
    input  logic             r_re,
    input  logic [SEL_W-1:0] r_sel,
    input  logic             r_bit,
    output logic             l_rbit,
    output logic             r_rbit,
    output logic [SEM_N-1:0] l_hold,
    output logic [SEM_N-1:0] r_hold
);

    for (genvar i = 0; i < SEM_N; i++) begin : g_latch
        sem_owner_e own_q;
        sem_owner_e own_n;
        logic       req_l_q;
        logic       req_r_q;
        logic       req_l_n;
        logic       req_r_n;
        logic       prio_q;
        logic       tie;

        // Next request flags and owner for this latch.
        always_comb begin
            req_l_n = req_l_q;
            req_r_n = req_r_q;
            if (l_we && (l_sel == SEL_W'(i))) req_l_n = ~l_bit;
            if (r_we && (r_sel == SEL_W'(i))) req_r_n = ~r_bit;
            tie = 1'b0;
            if ((own_q == SEM_LEFT) && req_l_n) begin
                own_n = SEM_LEFT;
            end else if ((own_q == SEM_RIGHT) && req_r_n) begin
                own_n = SEM_RIGHT;
            end else if (req_l_n && req_r_n) begin
                tie   = 1'b1;
                own_n = prio_q ? SEM_RIGHT : SEM_LEFT;
            end else if (req_l_n) begin
                own_n = SEM_LEFT;
            end else if (req_r_n) begin
                own_n = SEM_RIGHT;
            end else begin
                own_n = SEM_FREE;
            end
        end

        // Latch state: requests, owner and tie priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_l_q <= 1'b0;
                req_r_q <= 1'b0;
                prio_q  <= 1'b0;
                own_q   <= SEM_FREE;
            end else begin
                req_l_q <= req_l_n;
                req_r_q <= req_r_n;
                prio_q  <= prio_q ^ tie;
                own_q   <= own_n;
            end
        end

        assign l_hold[i] = (own_q == SEM_LEFT);
        assign r_hold[i] = (own_q == SEM_RIGHT);
    end

    // Left read-back: 0 when the left side holds the selected token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_rbit <= 1'b0;
        end else if (l_re) begin
            l_rbit <= ~l_hold[l_sel];
        end
    end

    // Right read-back: 0 when the right side holds the selected token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_rbit <= 1'b0;
        end else if (r_re) begin
            r_rbit <= ~r_hold[r_sel];
        end
    end

endmodule

// File: rtl/dpr_mbox_sem.sv
// Module: top of the shared two-port memory with mailboxes and token latches.
// Decodes each port's strobes into array, mailbox and token-latch traffic and
// selects the read-data source registered alongside the read request.
// Assumes: DATA_W is a multiple of 8 and SEM_N is a power of two, at least 2.
module dpr_mbox_sem #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 16,
    parameter int SEM_N  = 8,
    localparam int NB    = DATA_W / 8,
    localparam int SEL_W = $clog2(SEM_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce,
    input  logic              l_rd,
    input  logic              l_wr,
    input  logic              l_sem,
    input  logic [NB-1:0]     l_be,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq,
    input  logic              r_ce,
    input  logic              r_rd,
    input  logic              r_wr,
    input  logic              r_sem,
    input  logic [NB-1:0]     r_be,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq
);

    logic              l_mem_we, l_mem_re, l_tok_we, l_tok_re;
    logic              r_mem_we, r_mem_re, r_tok_we, r_tok_re;
    logic [DATA_W-1:0] l_mem_q, r_mem_q;
    logic              l_tok_bit, r_tok_bit;
    logic              l_src_tok_q, r_src_tok_q;
    logic [SEM_N-1:0]  sem_l_hold, sem_r_hold;
    logic [1:0]        box_irq;

    assign l_mem_we = l_ce && l_wr && !l_sem;
    assign l_mem_re = l_ce && l_rd && !l_sem;
    assign l_tok_we = l_ce && l_wr && l_sem;
    assign l_tok_re = l_ce && l_rd && l_sem;
    assign r_mem_we = r_ce && r_wr && !r_sem;
    assign r_mem_re = r_ce && r_rd && !r_sem;
    assign r_tok_we = r_ce && r_wr && r_sem;
    assign r_tok_re = r_ce && r_rd && r_sem;

    dpr_mem_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_we    (l_mem_we),
        .l_re    (l_mem_re),
        .l_be    (l_be),
        .l_addr  (l_addr),
        .l_wdata (l_wdata),
        .l_q     (l_mem_q),
        .r_we    (r_mem_we),
        .r_re    (r_mem_re),
        .r_be    (r_be),
        .r_addr  (r_addr),
        .r_wdata (r_wdata),
        .r_q     (r_mem_q)
    );

    dpr_mailbox #(
        .ADDR_W (ADDR_W)
    ) u_box (
        .clk   (clk),
        .rst_n (rst_n),
        .we    ({r_mem_we, l_mem_we}),
        .re    ({r_mem_re, l_mem_re}),
        .addr  ({r_addr, l_addr}),
        .irq   (box_irq)
    );

    dpr_sem_bank #(
        .SEM_N (SEM_N)
    ) u_tokens (
        .clk    (clk),
        .rst_n  (rst_n),
        .l_we   (l_tok_we),
        .l_re   (l_tok_re),
        .l_sel  (l_addr[SEL_W-1:0]),
        .l_bit  (l_wdata[0]),
        .r_we   (r_tok_we),
        .r_re   (r_tok_re),
        .r_sel  (r_addr[SEL_W-1:0]),
        .r_bit  (r_wdata[0]),
        .l_rbit (l_tok_bit),
        .r_rbit (r_tok_bit),
        .l_hold (sem_l_hold),
        .r_hold (sem_r_hold)
    );

    // Remember whether each port's latest read targeted the token latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_src_tok_q <= 1'b0;
            r_src_tok_q <= 1'b0;
        end else begin
            if (l_ce && l_rd) l_src_tok_q <= l_sem;
            if (r_ce && r_rd) r_src_tok_q <= r_sem;
        end
    end

    assign l_rdata = l_src_tok_q ? {{(DATA_W-1){1'b0}}, l_tok_bit} : l_mem_q;
    assign r_rdata = r_src_tok_q ? {{(DATA_W-1){1'b0}}, r_tok_bit} : r_mem_q;
    assign l_irq   = box_irq[0];
    assign r_irq   = box_irq[1];

endmodule

// File: rtl/dpr_mbox_sem_chk.sv
// Module: assertion checker bound to dpr_mbox_sem.
// Assumes: connected to the top's ports and its token-holder vectors.
module dpr_mbox_sem_chk #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 16,
    parameter int SEM_N  = 8,
    localparam int SEL_W = $clog2(SEM_N)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_ce,
    input logic              l_rd,
    input logic              l_wr,
    input logic              l_sem,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_wbit,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_irq,
    input logic [SEM_N-1:0]  l_hold,
    input logic              r_ce,
    input logic              r_rd,
    input logic              r_wr,
    input logic              r_sem,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_wbit,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_irq,
    input logic [SEM_N-1:0]  r_hold
);

    localparam logic [ADDR_W-1:0] TOP_W = '1;
    localparam logic [ADDR_W-1:0] LOW_W = TOP_W - ADDR_W'(1);

    a_r4_left_bell: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ce && r_wr && !r_sem && r_addr == LOW_W) |=> l_irq)
        else $error("R4 left interrupt not raised");

    a_r5_right_bell: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce && l_wr && !l_sem && l_addr == TOP_W) |=> r_irq)
        else $error("R5 right interrupt not raised");

    a_r6_left_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce && l_rd && !l_sem && l_addr == LOW_W
         && !(r_ce && r_wr && !r_sem && r_addr == LOW_W)) |=> !l_irq)
        else $error("R6 left interrupt not cleared");

    a_r6_right_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ce && r_rd && !r_sem && r_addr == TOP_W
         && !(l_ce && l_wr && !l_sem && l_addr == TOP_W)) |=> !r_irq)
        else $error("R6 right interrupt not cleared");

    a_r3_left_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !l_ce |=> $stable(l_rdata))
        else $error("R3 left read data moved while disabled");

    a_r3_right_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !r_ce |=> $stable(r_rdata))
        else $error("R3 right read data moved while disabled");

    a_r8_left_tok_width: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce && l_rd && l_sem) |=> (l_rdata[DATA_W-1:1] == '0))
        else $error("R8 left token read has upper bits set");

    a_r8_right_tok_width: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ce && r_rd && r_sem) |=> (r_rdata[DATA_W-1:1] == '0))
        else $error("R8 right token read has upper bits set");

    for (genvar i = 0; i < SEM_N; i++) begin : g_tok
        a_r10_left_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (l_hold[i] && !(l_ce && l_wr && l_sem
                            && l_addr[SEL_W-1:0] == SEL_W'(i) && l_wbit))
            |=> l_hold[i])
            else $error("R10 left lost a token it did not release");

        a_r10_right_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (r_hold[i] && !(r_ce && r_wr && r_sem
                            && r_addr[SEL_W-1:0] == SEL_W'(i) && r_wbit))
            |=> r_hold[i])
            else $error("R10 right lost a token it did not release");

        a_r11_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
            (!l_hold[i] && !r_hold[i]
             && l_ce && l_wr && l_sem && !l_wbit && l_addr[SEL_W-1:0] == SEL_W'(i)
             && r_ce && r_wr && r_sem && !r_wbit && r_addr[SEL_W-1:0] == SEL_W'(i))
            |=> (l_hold[i] ^ r_hold[i]))
            else $error("R11 tie did not grant exactly one side");
    end

endmodule

bind dpr_mbox_sem dpr_mbox_sem_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SEM_N  (SEM_N)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_ce    (l_ce),
    .l_rd    (l_rd),
    .l_wr    (l_wr),
    .l_sem   (l_sem),
    .l_addr  (l_addr),
    .l_wbit  (l_wdata[0]),
    .l_rdata (l_rdata),
    .l_irq   (l_irq),
    .l_hold  (sem_l_hold),
    .r_ce    (r_ce),
    .r_rd    (r_rd),
    .r_wr    (r_wr),
    .r_sem   (r_sem),
    .r_addr  (r_addr),
    .r_wbit  (r_wdata[0]),
    .r_rdata (r_rdata),
    .r_irq   (r_irq),
    .r_hold  (sem_r_hold)
);

// File: tb/dpr_mbox_sem_bench.sv
// Bench: sweeps a 64-word build of dpr_mbox_sem; expected values are computed here.
module dpr_mbox_sem_bench;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int SN = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          l_ce, l_rd, l_wr, l_sem, r_ce, r_rd, r_wr, r_sem;
    logic [1:0]    l_be, r_be;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic          l_irq, r_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dpr_mbox_sem #(.ADDR_W(AW), .DATA_W(DW), .SEM_N(SN)) u_dpr_mbox_sem (
        .clk(clk), .rst_n(rst_n),
        .l_ce(l_ce), .l_rd(l_rd), .l_wr(l_wr), .l_sem(l_sem), .l_be(l_be),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq(l_irq),
        .r_ce(r_ce), .r_rd(r_rd), .r_wr(r_wr), .r_sem(r_sem), .r_be(r_be),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq(r_irq)
    );

    function automatic logic [15:0] pat(int a);
        return 16'((a * 613) ^ 16'hC3A5 ^ (a << 10));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        l_ce = 0; l_rd = 0; l_wr = 0; l_sem = 0; l_be = 0; l_addr = 0; l_wdata = 0;
        r_ce = 0; r_rd = 0; r_wr = 0; r_sem = 0; r_be = 0; r_addr = 0; r_wdata = 0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(bit side, int a, logic [15:0] d, logic [1:0] be, bit sem);
        if (!side) begin
            l_ce = 1; l_wr = 1; l_addr = AW'(a); l_wdata = d; l_be = be; l_sem = sem;
        end else begin
            r_ce = 1; r_wr = 1; r_addr = AW'(a); r_wdata = d; r_be = be; r_sem = sem;
        end
    endtask

    task automatic rd(bit side, int a, bit sem);
        if (!side) begin
            l_ce = 1; l_rd = 1; l_addr = AW'(a); l_sem = sem;
        end else begin
            r_ce = 1; r_rd = 1; r_addr = AW'(a); r_sem = sem;
        end
    endtask

    // One-cycle operation on one side, then idle.
    task automatic op_wr(bit side, int a, logic [15:0] d, logic [1:0] be, bit sem);
        idle(); wr(side, a, d, be, sem); tick(); idle();
    endtask

    // Read both latches of index i in one cycle and compare.
    task automatic tok_both(string req, int i, logic el, logic er);
        idle(); rd(0, i, 1); rd(1, i, 1); tick();
        check({req, " left token read"}, l_rdata, {15'b0, el});
        check({req, " right token read"}, r_rdata, {15'b0, er});
        idle();
    endtask

    task automatic mem_read(string req, bit side, int a, logic [15:0] exp);
        idle(); rd(side, a, 0); tick();
        check(req, side ? r_rdata : l_rdata, exp);
        idle();
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        // R7: reset state
        check("R7 l_irq after reset", l_irq, 0);
        check("R7 r_irq after reset", r_irq, 0);
        check("R7 l_rdata after reset", l_rdata, 0);
        check("R7 r_rdata after reset", r_rdata, 0);
        // R9: every latch free after reset
        for (int i = 0; i < SN; i++) tok_both("R9 reset free", i, 1, 1);

        // R1: concurrent fill, left low half, right high half
        for (int a = 0; a < 32; a++) begin
            idle(); wr(0, a, pat(a), 2'b11, 0); wr(1, a + 32, pat(a + 32), 2'b11, 0); tick();
        end
        idle();
        check("R4 sweep wrote 0x3E from right", l_irq, 1);
        check("R5 left never wrote 0x3F", r_irq, 0);
        // R1: concurrent read-back in opposite orders
        for (int a = 0; a < 64; a++) begin
            idle(); rd(0, a, 0); rd(1, 63 - a, 0); tick();
            check("R1 left read-back", l_rdata, pat(a));
            check("R1 right read-back", r_rdata, pat(63 - a));
        end
        idle(); tick();
        check("R6 left read of 0x3E cleared l_irq", l_irq, 0);
        check("R3 read data held while idle", l_rdata, pat(63));

        // R3: disabled port writes nothing
        idle(); l_wr = 1; l_addr = 5; l_wdata = 16'hFFFF; l_be = 2'b11;
        r_rd = 1; r_wr = 1; r_addr = 6; r_wdata = 16'hFFFF; r_be = 2'b11; tick();
        check("R3 r_rdata unchanged while disabled", r_rdata, pat(0));
        mem_read("R3 left write with ce low", 0, 5, pat(5));
        mem_read("R3 right write with ce low", 1, 6, pat(6));

        // R2: byte lanes
        op_wr(0, 10, 16'hABCD, 2'b10, 0);
        mem_read("R2 upper lane only", 1, 10, {8'hAB, pat(10)[7:0]});
        op_wr(1, 10, 16'h1234, 2'b01, 0);
        mem_read("R2 lower lane only", 0, 10, 16'hAB34);
        op_wr(0, 10, 16'h0000, 2'b00, 0);
        mem_read("R2 no lanes enabled", 0, 10, 16'hAB34);

        // R12: same-word collision
        idle(); wr(0, 20, 16'h1111, 2'b11, 0); wr(1, 20, 16'h2222, 2'b11, 0); tick(); idle();
        mem_read("R12 left wins collision", 1, 20, 16'h1111);

        // R4 / R6: left doorbell
        op_wr(1, 62, 16'h0000, 2'b00, 0);
        check("R4 right write to 0x3E raises l_irq", l_irq, 1);
        mem_read("R2 doorbell write with no lanes kept data", 1, 62, pat(62));
        check("R6 right read of 0x3E keeps l_irq", l_irq, 1);
        mem_read("R6 left read elsewhere", 0, 61, pat(61));
        check("R6 left read of 0x3D keeps l_irq", l_irq, 1);
        mem_read("R6 left read of 0x3E", 0, 62, pat(62));
        check("R6 left read of 0x3E clears l_irq", l_irq, 0);
        // R5 / R6: right doorbell
        op_wr(0, 63, 16'h7777, 2'b11, 0);
        check("R5 left write to 0x3F raises r_irq", r_irq, 1);
        check("R5 l_irq untouched", l_irq, 0);
        mem_read("R6 left reads 0x3F", 0, 63, 16'h7777);
        check("R6 left read of 0x3F keeps r_irq", r_irq, 1);
        mem_read("R6 right reads 0x3F", 1, 63, 16'h7777);
        check("R6 right read of 0x3F clears r_irq", r_irq, 0);
        // R6: set wins over clear
        idle(); wr(1, 62, 16'h0001, 2'b11, 0); rd(0, 62, 0); tick(); idle();
        check("R6 set beats same-cycle clear", l_irq, 1);
        mem_read("R6 clear after collision", 0, 62, 16'h0001);
        check("R6 l_irq cleared", l_irq, 0);

        // R8: token access leaves the array alone
        op_wr(0, 3, 16'hFFFE, 2'b11, 1);
        mem_read("R8 token write left word 3 intact", 1, 3, pat(3));
        // R9: left holds latch 3
        tok_both("R9 left granted latch 3", 3, 0, 1);
        // R10: right pending, then handover
        op_wr(1, 3, 16'h0000, 2'b11, 1);
        tok_both("R10 right pending", 3, 0, 1);
        op_wr(0, 3, 16'h0001, 2'b11, 1);
        tok_both("R10 handover to pending right", 3, 1, 0);
        op_wr(1, 3, 16'h0001, 2'b11, 1);
        tok_both("R10 right release frees latch 3", 3, 1, 1);
        // R10: non-holder write of 1 has no effect on holder
        op_wr(1, 4, 16'h0001, 2'b11, 1);
        tok_both("R10 release of free latch", 4, 1, 1);
        op_wr(0, 4, 16'h0000, 2'b11, 1);
        op_wr(1, 4, 16'h0001, 2'b11, 1);
        tok_both("R10 non-holder write keeps holder", 4, 0, 1);
        op_wr(0, 4, 16'h0001, 2'b11, 1);
        // R10: withdrawn request is not granted
        op_wr(0, 5, 16'h0000, 2'b11, 1);
        op_wr(1, 5, 16'h0000, 2'b11, 1);
        op_wr(1, 5, 16'h0001, 2'b11, 1);
        op_wr(0, 5, 16'h0001, 2'b11, 1);
        tok_both("R10 withdrawn request stays free", 5, 1, 1);
        tok_both("R8 untouched latch 6 free", 6, 1, 1);

        // R11: two ties on every latch, left first then right
        for (int rnd = 0; rnd < 2; rnd++) begin
            for (int i = 0; i < SN; i++) begin
                idle(); wr(0, i, 16'h0000, 2'b11, 1); wr(1, i, 16'h0000, 2'b11, 1); tick();
                tok_both("R11 tie", i, rnd[0], ~rnd[0]);
                idle(); wr(0, i, 16'h0001, 2'b11, 1); wr(1, i, 16'h0001, 2'b11, 1); tick();
                tok_both("R11 both release", i, 1, 1);
            end
        end
        idle(); wr(0, 0, 16'h0000, 2'b11, 1); wr(1, 0, 16'h0000, 2'b11, 1); tick();
        tok_both("R11 third tie on latch 0", 0, 0, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule